// File: doc/BRIEF.md
# Parallel NOR Flash Read Response Selector

This block forms the read side of a parallel NOR flash model. A command sequencer, which lives outside the block, reports which mode the device is in. On every bus read this block picks the value that goes back to the host. In plain read mode that value is the array word. In identification mode it is a maker or part code. While a program or erase is in progress it is the status byte. In query mode it is a byte from a computed parameter table. The storage array sits outside the block. This block hands it the wrapped byte address and takes back the word stored there.

The block owns the status byte. Each status read flips bit 6, which gives the host a toggle it can poll. The block also tracks whether the device sits in fast array-read mode. The first write of a command sequence drops the device out of that mode. After a fixed number of reads with no command pending, the block restores fast mode by itself. A command state code the block does not know is served as a plain array read, and the block raises a flag so the sequencer can reset.

Top module: `nor_read_mux`

## Requirements
- R1: After reset, fastRead is 1, stateFault is 0 and the status byte is 0x00.
- R2: In read mode (cmdState 0) and erase setup mode (cmdState 1), rdData is the array word. arrData carries the byte at the lowest address in bits [7:0]. With BIG_ENDIAN=0 the word is returned as it arrives. With BIG_ENDIAN=1 its bytes are returned in reverse order.
- R3: In identification mode (cmdState 2), word index 0 returns MFR_ID, index 1 returns DEV_ID and index 2 returns 0. Every other index returns the array word, apart from the cases in R4.
- R4: In identification mode, word indices 0x0E and 0x0F return EXT_ID0 and EXT_ID1. A code equal to 16'h00FF counts as undefined, and its index returns the array word instead.
- R5: In program, sector erase or chip erase mode (cmdState 3, 4 or 5), rdData is the status byte, zero-extended. Each such read inverts status bit 6 at the clock edge and leaves the other bits alone. A statusLoad pulse writes statusLoadVal and takes priority over the toggle. Reads in any other mode leave the status byte unchanged.
- R6: In query mode (cmdState 6), indices 0x10 to 0x12 return 'Q', 'R' and 'Y', and index 0x13 returns 0x02. Indices at or beyond 0x52 return 0.
- R7: The query byte at index 0x27 equals CHIP_AW, which is log2 of the chip size in bytes. Index 0x2D returns the low byte of (sector count - 1), and index 0x2F returns bits [15:8] of the sector size.
- R8: arrAddr is rdOffset wrapped to CHIP_AW bits. The table word index is rdOffset[7:0] shifted right by log2(BUS_BYTES), so higher offset bits do not affect which table entry is selected.
- R9: A read counts only while fastRead is 0 and seqIdle is 1. fastRead returns to 1 at the edge of the read that takes the count past LAZY_LIMIT, which is read number LAZY_LIMIT+1.
- R10: A wrStart pulse clears fastRead and the read count at the next edge.
- R11: A read with cmdState 7 returns the array word, as in R2, and drives stateFault to 1 during that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdStrobe | input | 1 | A bus read is taking place in this cycle |
| rdOffset | input | OFS_W | Byte offset of the read |
| cmdState | input | 3 | Mode code from the sequencer |
| seqIdle | input | 1 | No command sequence is pending |
| wrStart | input | 1 | First write of a new command sequence |
| statusLoad | input | 1 | Load the status byte |
| statusLoadVal | input | 8 | Value to load into the status byte |
| arrData | input | 8*BUS_BYTES | Array word at arrAddr |
| rdData | output | 8*BUS_BYTES | Read response |
| arrAddr | output | CHIP_AW | Wrapped byte address sent to the array |
| fastRead | output | 1 | Device is in fast array-read mode |
| stateFault | output | 1 | Read seen with an unknown mode code |

## Verification
The bench builds two copies of the block, both with a 64 KiB chip, 4 KiB sectors and a two-byte bus. One copy uses little-endian byte order and the other big-endian, so a single array word shows both orders. EXT_ID1 is set to the undefined code, which exercises both the path that returns an extended code and the path that falls through to the array. LAZY_LIMIT is kept at 42, which puts the exact cycle where fast mode comes back within a short run of reads.

// File: rtl/nor_read_pkg.sv
package nor_read_pkg;

  typedef enum logic [2:0] {
    MODE_READ    = 3'd0,
    MODE_ERSETUP = 3'd1,
    MODE_IDENT   = 3'd2,
    MODE_PROG    = 3'd3,
    MODE_SERASE  = 3'd4,
    MODE_CERASE  = 3'd5,
    MODE_QUERY   = 3'd6,
    MODE_BAD     = 3'd7
  } mode_e;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic selId;
    logic selStatus;
    logic selQuery;
    logic toggleStatus;
  } rd_strobes_t;

endpackage

// File: rtl/nor_read_ctl.sv
module nor_read_ctl
  import nor_read_pkg::*;
#(
  parameter int LAZY_LIMIT = 42
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdStrobe,
  input  logic [2:0]  cmdState,
  input  logic        seqIdle,
  input  logic        wrStart,
  output rd_strobes_t strb,
  output logic        fastRead,
  output logic        stateFault
);

  localparam int CNT_W = $clog2(LAZY_LIMIT + 2);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(LAZY_LIMIT);

  mode_e mode;
  logic [CNT_W-1:0] readCnt;
  logic countRead;

  assign mode = mode_e'(cmdState);

  always_comb begin
    strb = '0;
    stateFault = 1'b0;
    case (mode)
      MODE_IDENT:  strb.selId = 1'b1;
      MODE_PROG, MODE_SERASE, MODE_CERASE: begin
        strb.selStatus    = 1'b1;
        strb.toggleStatus = rdStrobe;
      end
      MODE_QUERY:  strb.selQuery = 1'b1;
      MODE_BAD:    stateFault = rdStrobe;
      default: ;
    endcase
  end

  assign countRead = rdStrobe && !fastRead && seqIdle;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readCnt  <= '0;
      fastRead <= 1'b1;
    end else if (wrStart) begin
      readCnt  <= '0;
      fastRead <= 1'b0;
    end else if (countRead) begin
      readCnt <= readCnt + 1'b1;
      if (readCnt >= LIM) fastRead <= 1'b1;
    end
  end

  // R9
  fast_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fastRead) |-> $past(rdStrobe) && $past(seqIdle) && !$past(wrStart));

  // R10
  wr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStart |=> !fastRead && readCnt == '0);

endmodule

// File: rtl/nor_read_dp.sv
module nor_read_dp
  import nor_read_pkg::*;
#(
  parameter int          BUS_BYTES  = 2,
  parameter int          CHIP_AW    = 16,
  parameter int          SECT_AW    = 12,
  parameter int          OFS_W      = 24,
  parameter bit          BIG_ENDIAN = 1'b0,
  parameter logic [15:0] MFR_ID     = 16'h0001,
  parameter logic [15:0] DEV_ID     = 16'h227E,
  parameter logic [15:0] EXT_ID0    = 16'h2210,
  parameter logic [15:0] EXT_ID1    = 16'h00FF
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  rd_strobes_t            strb,
  input  logic [OFS_W-1:0]       rdOffset,
  input  logic                   statusLoad,
  input  logic [7:0]             statusLoadVal,
  input  logic [8*BUS_BYTES-1:0] arrData,
  output logic [8*BUS_BYTES-1:0] rdData,
  output logic [CHIP_AW-1:0]     arrAddr
);

  localparam int          DATA_W   = 8 * BUS_BYTES;
  localparam int          SHIFT    = $clog2(BUS_BYTES);
  localparam int          QRY_LEN  = 'h52;
  localparam logic [15:0] ID_UNDEF = 16'h00FF;
  localparam int          NBLK_M1  = (1 << (CHIP_AW - SECT_AW)) - 1;
  localparam int          SECT_B   = 1 << SECT_AW;

  logic [7:0]        statusReg;
  logic [7:0]        idx;
  logic [DATA_W-1:0] arrayWord;
  logic              unusedHi;

  assign arrAddr  = rdOffset[CHIP_AW-1:0];
  assign unusedHi = ^rdOffset[OFS_W-1:CHIP_AW];
  assign idx      = rdOffset[7:0] >> SHIFT;

  generate
    if (BIG_ENDIAN) begin : g_swap
      for (genvar k = 0; k < BUS_BYTES; k++) begin : g_lane
        assign arrayWord[8*k +: 8] = arrData[8*(BUS_BYTES-1-k) +: 8];
      end
    end else begin : g_pass
      assign arrayWord = arrData;
    end
  endgenerate

  function automatic logic [7:0] qryByte(input logic [7:0] i);
    case (i)
      8'h10: qryByte = 8'h51;
      8'h11: qryByte = 8'h52;
      8'h12: qryByte = 8'h59;
      8'h13: qryByte = 8'h02;
      8'h15: qryByte = 8'h31;
      8'h1B: qryByte = 8'h27;
      8'h1C: qryByte = 8'h36;
      8'h1F: qryByte = 8'h07;
      8'h21: qryByte = 8'h09;
      8'h22: qryByte = 8'h0C;
      8'h23: qryByte = 8'h01;
      8'h25: qryByte = 8'h0A;
      8'h26: qryByte = 8'h0D;
      8'h27: qryByte = 8'(CHIP_AW);
      8'h28: qryByte = 8'h02;
      8'h2C: qryByte = 8'h01;
      8'h2D: qryByte = 8'(NBLK_M1);
      8'h2E: qryByte = 8'(NBLK_M1 >> 8);
      8'h2F: qryByte = 8'(SECT_B >> 8);
      8'h30: qryByte = 8'(SECT_B >> 16);
      8'h31: qryByte = 8'h50;
      8'h32: qryByte = 8'h52;
      8'h33: qryByte = 8'h49;
      8'h34: qryByte = 8'h31;
      8'h35: qryByte = 8'h30;
      default: qryByte = 8'h00;
    endcase
  endfunction

  always_comb begin
    rdData = arrayWord;
    if (strb.selStatus) begin
      rdData = DATA_W'(statusReg);
    end else if (strb.selQuery) begin
      rdData = (int'(idx) < QRY_LEN) ? DATA_W'(qryByte(idx)) : '0;
    end else if (strb.selId) begin
      case (idx)
        8'h00: rdData = DATA_W'(MFR_ID);
        8'h01: rdData = DATA_W'(DEV_ID);
        8'h02: rdData = '0;
        8'h0E: if (EXT_ID0 != ID_UNDEF) rdData = DATA_W'(EXT_ID0);
        8'h0F: if (EXT_ID1 != ID_UNDEF) rdData = DATA_W'(EXT_ID1);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  statusReg <= 8'h00;
    else if (statusLoad)        statusReg <= statusLoadVal;
    else if (strb.toggleStatus) statusReg[6] <= ~statusReg[6];
  end

  // R5
  status_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.toggleStatus && !statusLoad |=>
      statusReg[6] != $past(statusReg[6]) && statusReg[7] == $past(statusReg[7])
      && statusReg[5:0] == $past(statusReg[5:0]));

  // R5
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.toggleStatus && !statusLoad |=> $stable(statusReg));

  // R6
  qry_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.selQuery && int'(idx) >= QRY_LEN |-> rdData == '0);

endmodule

// File: rtl/nor_read_mux.sv
module nor_read_mux
  import nor_read_pkg::*;
#(
  parameter int          BUS_BYTES  = 2,
  parameter int          CHIP_AW    = 16,
  parameter int          SECT_AW    = 12,
  parameter int          OFS_W      = 24,
  parameter bit          BIG_ENDIAN = 1'b0,
  parameter int          LAZY_LIMIT = 42,
  parameter logic [15:0] MFR_ID     = 16'h0001,
  parameter logic [15:0] DEV_ID     = 16'h227E,
  parameter logic [15:0] EXT_ID0    = 16'h2210,
  parameter logic [15:0] EXT_ID1    = 16'h00FF
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   rdStrobe,
  input  logic [OFS_W-1:0]       rdOffset,
  input  logic [2:0]             cmdState,
  input  logic                   seqIdle,
  input  logic                   wrStart,
  input  logic                   statusLoad,
  input  logic [7:0]             statusLoadVal,
  input  logic [8*BUS_BYTES-1:0] arrData,
  output logic [8*BUS_BYTES-1:0] rdData,
  output logic [CHIP_AW-1:0]     arrAddr,
  output logic                   fastRead,
  output logic                   stateFault
);

  rd_strobes_t strb;

  nor_read_ctl #(.LAZY_LIMIT(LAZY_LIMIT)) i_ctl (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .cmdState(cmdState),
    .seqIdle(seqIdle), .wrStart(wrStart), .strb(strb),
    .fastRead(fastRead), .stateFault(stateFault)
  );

  nor_read_dp #(
    .BUS_BYTES(BUS_BYTES), .CHIP_AW(CHIP_AW), .SECT_AW(SECT_AW), .OFS_W(OFS_W),
    .BIG_ENDIAN(BIG_ENDIAN), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID),
    .EXT_ID0(EXT_ID0), .EXT_ID1(EXT_ID1)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdOffset(rdOffset),
    .statusLoad(statusLoad), .statusLoadVal(statusLoadVal),
    .arrData(arrData), .rdData(rdData), .arrAddr(arrAddr)
  );

endmodule

// File: tb/test_nor_read_mux.sv
`timescale 1ns/1ps
module test_nor_read_mux;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdStrobe = 1'b0;
  logic [23:0] rdOffset = '0;
  logic [2:0]  cmdState = 3'd0;
  logic        seqIdle = 1'b1;
  logic        wrStart = 1'b0;
  logic        statusLoad = 1'b0;
  logic [7:0]  statusLoadVal = '0;
  logic [15:0] arrData = 16'hA55A;
  logic [15:0] rdData, rdDataBe;
  logic [15:0] arrAddr, arrAddrBe;
  logic        fastRead, fastReadBe, stateFault, stateFaultBe;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  nor_read_mux i_nor_read_mux (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .rdOffset(rdOffset),
    .cmdState(cmdState), .seqIdle(seqIdle), .wrStart(wrStart),
    .statusLoad(statusLoad), .statusLoadVal(statusLoadVal), .arrData(arrData),
    .rdData(rdData), .arrAddr(arrAddr), .fastRead(fastRead), .stateFault(stateFault)
  );

  nor_read_mux #(.BIG_ENDIAN(1'b1)) i_nor_read_mux_be (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .rdOffset(rdOffset),
    .cmdState(cmdState), .seqIdle(seqIdle), .wrStart(wrStart),
    .statusLoad(statusLoad), .statusLoadVal(statusLoadVal), .arrData(arrData),
    .rdData(rdDataBe), .arrAddr(arrAddrBe), .fastRead(fastReadBe),
    .stateFault(stateFaultBe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  logic [15:0] gotLe, gotBe;
  logic        gotFault;

  task automatic rd(input logic [2:0] c, input logic [23:0] o);
    @(negedge clk);
    cmdState = c; rdOffset = o; rdStrobe = 1'b1;
    #1;
    gotLe = rdData; gotBe = rdDataBe; gotFault = stateFault;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic pulseWr();
    @(negedge clk); wrStart = 1'b1;
    @(negedge clk); wrStart = 1'b0;
  endtask

  task automatic loadStatus(input logic [7:0] v);
    @(negedge clk); statusLoad = 1'b1; statusLoadVal = v;
    @(negedge clk); statusLoad = 1'b0;
  endtask

  task automatic resetTest();
    check("R1 fastRead", fastRead, 1);
    check("R1 stateFault", stateFault, 0);
    rd(3'd3, 24'h0);
    check("R1 status after reset", gotLe, 16'h0000);
  endtask

  task automatic arrayTest();
    rd(3'd0, 24'h000010);
    check("R2 read LE", gotLe, 16'hA55A);
    check("R2 read BE", gotBe, 16'h5AA5);
    rd(3'd1, 24'h000040);
    check("R2 erase setup", gotLe, 16'hA55A);
  endtask

  task automatic idTest();
    rd(3'd2, 24'h0); check("R3 maker code", gotLe, 16'h0001);
    rd(3'd2, 24'h2); check("R3 part code", gotLe, 16'h227E);
    rd(3'd2, 24'h4); check("R3 protect", gotLe, 16'h0000);
    rd(3'd2, 24'h6); check("R3 fallthrough", gotLe, 16'hA55A);
    rd(3'd2, 24'h1C); check("R4 ext code 0", gotLe, 16'h2210);
    rd(3'd2, 24'h1E); check("R4 ext undef", gotLe, 16'hA55A);
  endtask

  task automatic statusTest();
    loadStatus(8'h80);
    rd(3'd3, 24'h0); check("R5 first read", gotLe, 16'h0080);
    rd(3'd3, 24'h0); check("R5 toggled", gotLe, 16'h00C0);
    rd(3'd4, 24'h0); check("R5 sector erase", gotLe, 16'h0080);
    rd(3'd0, 24'h0);
    rd(3'd5, 24'h0); check("R5 no toggle on array read", gotLe, 16'h00C0);
    @(negedge clk);
    cmdState = 3'd3; rdStrobe = 1'b1; statusLoad = 1'b1; statusLoadVal = 8'h05;
    @(negedge clk);
    rdStrobe = 1'b0; statusLoad = 1'b0;
    rd(3'd3, 24'h0); check("R5 load beats toggle", gotLe, 16'h0005);
  endtask

  task automatic queryTest();
    rd(3'd6, 24'h20); check("R6 Q", gotLe, 16'h0051);
    rd(3'd6, 24'h22); check("R6 R", gotLe, 16'h0052);
    rd(3'd6, 24'h24); check("R6 Y", gotLe, 16'h0059);
    rd(3'd6, 24'h26); check("R6 cmd set", gotLe, 16'h0002);
    rd(3'd6, 24'hA4); check("R6 at length", gotLe, 16'h0000);
    rd(3'd6, 24'hC0); check("R6 beyond", gotLe, 16'h0000);
    rd(3'd6, 24'h4E); check("R7 size", gotLe, 16'h0010);
    rd(3'd6, 24'h5A); check("R7 blocks", gotLe, 16'h000F);
    rd(3'd6, 24'h5E); check("R7 sector size", gotLe, 16'h0010);
  endtask

  task automatic indexTest();
    @(negedge clk); rdOffset = 24'h012346; #1;
    check("R8 wrap", arrAddr, 16'h2346);
    rd(3'd6, 24'h050320); check("R8 low byte index", gotLe, 16'h0051);
    rd(3'd2, 24'h000100); check("R8 index ignores bit 8", gotLe, 16'h0001);
  endtask

  task automatic lazyTest();
    pulseWr();
    check("R10 wrStart clears", fastRead, 0);
    seqIdle = 1'b0;
    for (int i = 0; i < 50; i++) rd(3'd0, 24'h0);
    check("R9 busy reads ignored", fastRead, 0);
    seqIdle = 1'b1;
    for (int i = 0; i < 42; i++) rd(3'd0, 24'h0);
    check("R9 still slow at limit", fastRead, 0);
    rd(3'd0, 24'h0);
    check("R9 restored", fastRead, 1);
    pulseWr();
    for (int i = 0; i < 30; i++) rd(3'd0, 24'h0);
    pulseWr();
    for (int i = 0; i < 42; i++) rd(3'd0, 24'h0);
    check("R10 count cleared", fastRead, 0);
    rd(3'd0, 24'h0);
    check("R10 restores after fresh count", fastRead, 1);
  endtask

  task automatic faultTest();
    rd(3'd7, 24'h0);
    check("R11 fault flag", gotFault, 1);
    check("R11 array data", gotLe, 16'hA55A);
    rd(3'd0, 24'h0);
    check("R11 no fault", gotFault, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    resetTest();
    arrayTest();
    idTest();
    statusTest();
    queryTest();
    indexTest();
    lazyTest();
    faultTest();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule